// File: doc/BRIEF.md
# Receive Busy-Acknowledge Decision Unit

This unit sits in the receive path of a serial-bus link layer. For each incoming packet header it decides two things: whether the packet is taken in, and which acknowledge code goes back to the sender. The header parser presents a per-packet descriptor with a one-cycle strobe. The descriptor holds the sender's retry code, a read/write flag, the 48-bit destination offset and a broadcast flag. The unit combines it with a receiver-busy signal and a set of static control fields. The registered decision appears one clock later and is held until the next strobe.

The control fields are a 3-bit busy mode, a receiver enable, a gate for the physical (direct-memory) window below 4 GB, and a broadcast mask over the bus-dependent CSR window. The busy mode has two parts. Its upper bit makes every packet receive a busy acknowledge. Its lower two bits choose how a busy code is picked: dual-phase, fixed busy_A, or fixed busy_B. In dual-phase operation the unit holds one phase bit. A retry packet is accepted only when its phase matches that bit, and the phase flips after such a packet is accepted.

Top module: `rxack_unit`

## Requirements
- R1: After reset, ack_valid and ack_accept are 0, ack_code is 0 (no acknowledge), and the phase bit selects phase A.
- R2: The outputs change only on the clock edge that samples hdr_valid high, so they are valid one cycle after the strobe. They hold their values while hdr_valid is low.
- R3: A strobe while cfg_rx_en is low gives ack_valid=0, ack_accept=0 and ack_code=0, and leaves the phase bit unchanged.
- R4: An accepted non-broadcast packet returns ack_complete (code 1) for a write and ack_pending (code 2) for a read.
- R5: Retry codes are 00 new, 01 retry_X, 10 retry_A and 11 retry_B. A non-broadcast retry_X packet that must be busied gets busy_X (code 4) in every mode.
- R6: Modes 001 and 010 busy a packet only when it is needed (rx_busy or the physical-busy rule). They return busy_A (code 5) and busy_B (code 6) respectively.
- R7: Modes 100, 101 and 110 busy every packet, with the code chosen as in modes 000, 001 and 010. No packet is accepted in these modes.
- R8: The reserved modes 011 and 111 behave exactly as mode 000.
- R9: A packet is busied when all of these hold: cfg_phys_on and cfg_phys_busy are high, the offset is below 2^32, and either the packet is a read or cfg_phys_ro is low.
- R10: With cfg_phys_on and cfg_phys_ro high, a write below 2^32 is dropped with ack_code 0.
- R11: A broadcast packet is dropped when its offset lies in quarter k (128 bytes each) of the 512-byte window at 0xFFFF_F000_0200 and cfg_bcast_mask[k] is 1. Bit 0 covers the lowest quarter and bit 3 the highest.
- R12: A broadcast packet always gets ack_code 0. It is accepted unless R11 filters it, the R10 rule applies, or busy is needed.
- R13: In mode 000/100 the busy code is busy_A in phase A and busy_B in phase B. A retry_A packet arriving in phase B, or a retry_B packet arriving in phase A, is busied. Accepting a matching retry_A or retry_B packet flips the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | One-cycle strobe: descriptor valid |
| hdr_retry | input | 2 | Retry code of the packet |
| hdr_is_read | input | 1 | 1 for a read request |
| hdr_offset | input | OFS_W (48) | Destination offset |
| hdr_bcast | input | 1 | Packet is a broadcast |
| rx_busy | input | 1 | Receiver cannot take the packet now |
| cfg_mode | input | 3 | Busy mode |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_phys_on | input | 1 | Physical window gate on |
| cfg_phys_ro | input | 1 | Physical window read-only |
| cfg_phys_busy | input | 1 | Physical window busy |
| cfg_bcast_mask | input | SLICES (4) | Broadcast block mask over window quarters |
| ack_valid | output | 1 | A decision is held for the last strobe |
| ack_accept | output | 1 | Packet accepted |
| ack_code | output | 4 | Acknowledge code (0 = none) |

## Verification
The assertions take two things for granted. The control fields are steady around a strobe, and a strobe lasts a single cycle with its descriptor valid in that same cycle. The bench drives all inputs at the falling edge and changes control fields only between strobes. It leaves at least one idle cycle between packets so that the hold behaviour is seen. Offsets are picked at the edges of the physical limit and of each window quarter, with retry codes and modes swept so that both phases of the dual-phase scheme are reached.

// File: rtl/rxack_pkg.sv
package rxack_pkg;

   typedef enum logic [3:0] {
      ACK_NONE     = 4'd0,
      ACK_COMPLETE = 4'd1,
      ACK_PENDING  = 4'd2,
      ACK_BUSY_X   = 4'd4,
      ACK_BUSY_A   = 4'd5,
      ACK_BUSY_B   = 4'd6
   } ack_e;

   typedef enum logic [1:0] {
      RTY_NEW = 2'd0,
      RTY_X   = 2'd1,
      RTY_A   = 2'd2,
      RTY_B   = 2'd3
   } retry_e;

   typedef enum logic [1:0] {
      PICK_PHASE = 2'd0,
      PICK_FIX_A = 2'd1,
      PICK_FIX_B = 2'd2
   } pick_e;

   typedef struct packed {
      logic  force_all;
      pick_e pick;
   } mode_t;

   // reserved encodings fold onto the dual-phase normal mode
   function automatic mode_t decode_mode(input logic [2:0] raw);
      mode_t m;
      if (raw[1:0] == 2'b11) begin
         m.force_all = 1'b0;
         m.pick      = PICK_PHASE;
      end else begin
         m.force_all = raw[2];
         m.pick      = pick_e'(raw[1:0]);
      end
      return m;
   endfunction

endpackage

// File: rtl/rxack_addr_class.sv
module rxack_addr_class #(
   parameter int              OFS_W      = 48,
   parameter int              PHYS_W     = 32,
   parameter logic [OFS_W-1:0] BD_BASE   = 48'hFFFF_F000_0200,
   parameter int              SLICE_LOG2 = 7,
   parameter int              SLICES     = 4
) (
   input  logic [OFS_W-1:0]  offset,
   input  logic [SLICES-1:0] block_mask,
   output logic              phys_low,
   output logic              win_blocked
);
   localparam int SEL_W   = (SLICES > 1) ? $clog2(SLICES) : 1;
   localparam int WIN_LSB = SLICE_LOG2 + SEL_W;
   localparam logic [OFS_W-1:0] WIN_SZ = OFS_W'(1) << WIN_LSB;

   if (PHYS_W < 1 || PHYS_W >= OFS_W) begin : g_bad_phys
      $error("rxack_addr_class: PHYS_W must lie in 1..OFS_W-1");
   end
   if (SLICES < 2 || (SLICES & (SLICES - 1)) != 0) begin : g_bad_slices
      $error("rxack_addr_class: SLICES must be a power of two, at least 2");
   end
   if (BD_BASE[WIN_LSB-1:0] != '0) begin : g_bad_base
      $error("rxack_addr_class: BD_BASE must be aligned to the window size");
   end

   logic [OFS_W-1:0]  diff;
   logic              in_win;
   logic [SLICES-1:0] slice_hit;

   assign phys_low = ~|offset[OFS_W-1:PHYS_W];
   assign diff     = offset - BD_BASE;
   assign in_win   = diff < WIN_SZ;

   for (genvar k = 0; k < SLICES; k++) begin : g_slice
      assign slice_hit[k] = in_win && (diff[WIN_LSB-1:SLICE_LOG2] == SEL_W'(k));
   end

   assign win_blocked = |(slice_hit & block_mask);

endmodule

// File: rtl/rxack_phase.sv
module rxack_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   output logic phase_b
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_b <= 1'b0;
      else if (advance) phase_b <= ~phase_b;
   end
endmodule

// File: rtl/rxack_policy.sv
module rxack_policy
   import rxack_pkg::*;
(
   input  logic [2:0] mode_raw,
   input  logic [1:0] retry_raw,
   input  logic       is_read,
   input  logic       bcast,
   input  logic       rx_busy,
   input  logic       phys_on,
   input  logic       phys_ro,
   input  logic       phys_busy,
   input  logic       phys_low,
   input  logic       win_blocked,
   input  logic       phase_b,
   output logic       accept,
   output ack_e       code,
   output logic       advance
);
   mode_t  m;
   retry_e rty;
   logic   phys_need_busy, phys_reject, phase_miss, need_busy, phased_retry;
   ack_e   busy_code;

   assign m   = decode_mode(mode_raw);
   assign rty = retry_e'(retry_raw);

   assign phys_need_busy = phys_on && phys_low && phys_busy && (is_read || !phys_ro);
   assign phys_reject    = phys_on && phys_low && phys_ro && !is_read;
   assign phased_retry   = (rty == RTY_A) || (rty == RTY_B);
   assign phase_miss     = (m.pick == PICK_PHASE) &&
                           (((rty == RTY_A) && phase_b) || ((rty == RTY_B) && !phase_b));
   assign need_busy      = m.force_all || rx_busy || phys_need_busy ||
                           (!bcast && phase_miss);

   always_comb begin
      if (rty == RTY_X) busy_code = ACK_BUSY_X;
      else begin
         unique case (m.pick)
            PICK_FIX_A: busy_code = ACK_BUSY_A;
            PICK_FIX_B: busy_code = ACK_BUSY_B;
            default:    busy_code = phase_b ? ACK_BUSY_B : ACK_BUSY_A;
         endcase
      end
   end

   always_comb begin
      accept = 1'b0;
      code   = ACK_NONE;
      if (bcast) begin
         accept = !win_blocked && !need_busy && !phys_reject;
      end else if (phys_reject) begin
         accept = 1'b0;
      end else if (need_busy) begin
         code   = busy_code;
      end else begin
         accept = 1'b1;
         code   = is_read ? ACK_PENDING : ACK_COMPLETE;
      end
   end

   assign advance = accept && !bcast && (m.pick == PICK_PHASE) && phased_retry;

endmodule

// File: rtl/rxack_unit.sv
module rxack_unit
   import rxack_pkg::*;
#(
   parameter int               OFS_W      = 48,
   parameter int               PHYS_W     = 32,
   parameter logic [OFS_W-1:0] BD_BASE    = 48'hFFFF_F000_0200,
   parameter int               SLICE_LOG2 = 7,
   parameter int               SLICES     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  logic [1:0]        hdr_retry,
   input  logic              hdr_is_read,
   input  logic [OFS_W-1:0]  hdr_offset,
   input  logic              hdr_bcast,
   input  logic              rx_busy,
   input  logic [2:0]        cfg_mode,
   input  logic              cfg_rx_en,
   input  logic              cfg_phys_on,
   input  logic              cfg_phys_ro,
   input  logic              cfg_phys_busy,
   input  logic [SLICES-1:0] cfg_bcast_mask,
   output logic              ack_valid,
   output logic              ack_accept,
   output logic [3:0]        ack_code
);
   logic phys_low, win_blocked, phase_b, pol_accept, pol_advance, phase_step;
   ack_e pol_code;

   rxack_addr_class #(
      .OFS_W(OFS_W), .PHYS_W(PHYS_W), .BD_BASE(BD_BASE),
      .SLICE_LOG2(SLICE_LOG2), .SLICES(SLICES)
   ) u_addr (
      .offset(hdr_offset), .block_mask(cfg_bcast_mask),
      .phys_low(phys_low), .win_blocked(win_blocked)
   );

   rxack_policy u_policy (
      .mode_raw(cfg_mode), .retry_raw(hdr_retry), .is_read(hdr_is_read),
      .bcast(hdr_bcast), .rx_busy(rx_busy), .phys_on(cfg_phys_on),
      .phys_ro(cfg_phys_ro), .phys_busy(cfg_phys_busy), .phys_low(phys_low),
      .win_blocked(win_blocked), .phase_b(phase_b),
      .accept(pol_accept), .code(pol_code), .advance(pol_advance)
   );

   assign phase_step = hdr_valid && cfg_rx_en && pol_advance;

   rxack_phase u_phase (
      .clk(clk), .rst_n(rst_n), .advance(phase_step), .phase_b(phase_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_valid  <= 1'b0;
         ack_accept <= 1'b0;
         ack_code   <= ACK_NONE;
      end else if (hdr_valid) begin
         ack_valid  <= cfg_rx_en;
         ack_accept <= cfg_rx_en && pol_accept;
         ack_code   <= cfg_rx_en ? pol_code : ACK_NONE;
      end
   end

   // R2: outputs frozen between strobes
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> $stable({ack_valid, ack_accept, ack_code}));
   // R2: an accept is always backed by a valid decision
   p_accept_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_accept |-> ack_valid);
   // R3: disabled receiver yields no acknowledge
   p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && !cfg_rx_en) |=> (!ack_valid && ack_code == 4'd0));
   // R4: an accepted unicast carries complete or pending
   p_accept_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && cfg_rx_en && !hdr_bcast) |=>
         (!ack_accept || ack_code == 4'd1 || ack_code == 4'd2));
   // R5: busy retry_X packets answer busy_X
   p_retry_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && cfg_rx_en && !hdr_bcast && hdr_retry == 2'b01 &&
       rx_busy && !cfg_phys_on) |=> (ack_code == 4'd4));
   // R7: forced busy modes never accept
   p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && cfg_mode[2] && cfg_mode[1:0] != 2'b11) |=> !ack_accept);
   // R12: broadcasts are never acknowledged
   p_bcast_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && hdr_bcast) |=> (ack_code == 4'd0));

endmodule

// File: tb/rxack_unit_bench.sv
`timescale 1ns/1ps
module rxack_unit_bench;
   localparam logic [47:0] BD = 48'hFFFF_F000_0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_valid = 1'b0;
   logic [1:0]  hdr_retry = 2'd0;
   logic        hdr_is_read = 1'b0;
   logic [47:0] hdr_offset = 48'd0;
   logic        hdr_bcast = 1'b0;
   logic        rx_busy = 1'b0;
   logic [2:0]  cfg_mode = 3'd0;
   logic        cfg_rx_en = 1'b1;
   logic        cfg_phys_on = 1'b0;
   logic        cfg_phys_ro = 1'b0;
   logic        cfg_phys_busy = 1'b0;
   logic [3:0]  cfg_bcast_mask = 4'd0;
   logic        ack_valid, ack_accept;
   logic [3:0]  ack_code;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req  = "R1";
   bit    finished = 1'b0;

   // reference state
   int exp_valid = 0, exp_accept = 0, exp_code = 0, ref_phase = 0;

   always #2 clk = ~clk;

   rxack_unit u_rxack_unit (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_retry(hdr_retry),
      .hdr_is_read(hdr_is_read), .hdr_offset(hdr_offset), .hdr_bcast(hdr_bcast),
      .rx_busy(rx_busy), .cfg_mode(cfg_mode), .cfg_rx_en(cfg_rx_en),
      .cfg_phys_on(cfg_phys_on), .cfg_phys_ro(cfg_phys_ro),
      .cfg_phys_busy(cfg_phys_busy), .cfg_bcast_mask(cfg_bcast_mask),
      .ack_valid(ack_valid), .ack_accept(ack_accept), .ack_code(ack_code)
   );

   task automatic model_step();
      int md, kind, q, bcode;
      bit force_all, low, pbusy, prej, miss, inwin, blk, busy, acc;
      if (!rst_n) begin
         exp_valid = 0; exp_accept = 0; exp_code = 0; ref_phase = 0;
         return;
      end
      if (!hdr_valid) return;
      if (!cfg_rx_en) begin
         exp_valid = 0; exp_accept = 0; exp_code = 0;
         return;
      end
      md = int'(cfg_mode);
      if ((md % 4) == 3) md = 0;
      force_all = (md >= 4);
      kind  = md % 4;
      low   = hdr_offset < 48'h1_0000_0000;
      pbusy = cfg_phys_on && low && cfg_phys_busy && (hdr_is_read || !cfg_phys_ro);
      prej  = cfg_phys_on && low && cfg_phys_ro && !hdr_is_read;
      miss  = (kind == 0) && ((hdr_retry == 2 && ref_phase == 1) ||
                              (hdr_retry == 3 && ref_phase == 0));
      inwin = (hdr_offset >= BD) && (hdr_offset < BD + 48'd512);
      q     = inwin ? int'((hdr_offset - BD) / 128) : 0;
      blk   = hdr_bcast && inwin && cfg_bcast_mask[q];
      busy  = force_all || rx_busy || pbusy || (!hdr_bcast && miss);
      if (hdr_retry == 1)  bcode = 4;
      else if (kind == 1)  bcode = 5;
      else if (kind == 2)  bcode = 6;
      else                 bcode = (ref_phase == 1) ? 6 : 5;
      exp_valid = 1;
      if (hdr_bcast) begin
         acc = !blk && !busy && !prej;
         exp_code = 0;
      end else if (prej) begin
         acc = 0; exp_code = 0;
      end else if (busy) begin
         acc = 0; exp_code = bcode;
      end else begin
         acc = 1; exp_code = hdr_is_read ? 2 : 1;
      end
      exp_accept = acc;
      if (acc && !hdr_bcast && kind == 0 && (hdr_retry == 2 || hdr_retry == 3))
         ref_phase = 1 - ref_phase;
   endtask

   always @(posedge clk) begin
      #1;
      model_step();
      n_checks++;
      if (int'(ack_valid) != exp_valid || int'(ack_accept) != exp_accept ||
          int'(ack_code) != exp_code) begin
         n_errors++;
         $display("FAIL %s t=%0t: valid/accept/code = %0d/%0d/%0d expected %0d/%0d/%0d",
                  cur_req, $time, ack_valid, ack_accept, ack_code,
                  exp_valid, exp_accept, exp_code);
      end
   end

   task automatic pkt(input string req, input logic [1:0] rty, input logic rd,
                      input logic [47:0] ofs, input logic bc, input logic busy);
      @(negedge clk);
      cur_req     = req;
      hdr_valid   = 1'b1;
      hdr_retry   = rty;
      hdr_is_read = rd;
      hdr_offset  = ofs;
      hdr_bcast   = bc;
      rx_busy     = busy;
      @(negedge clk);
      hdr_valid   = 1'b0;
      hdr_retry   = 2'd3;
      hdr_offset  = ~ofs;
      rx_busy     = ~busy;
      @(negedge clk);
   endtask

   task automatic set_cfg(input logic [2:0] md, input logic en, input logic pon,
                          input logic pro, input logic pbz, input logic [3:0] msk);
      @(negedge clk);
      cfg_mode = md; cfg_rx_en = en; cfg_phys_on = pon;
      cfg_phys_ro = pro; cfg_phys_busy = pbz; cfg_bcast_mask = msk;
   endtask

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 plain accepts
      set_cfg(3'd0, 1, 0, 0, 0, 4'h0);
      pkt("R4", 2'd0, 0, 48'h0000_1000_0000, 0, 0);
      pkt("R4", 2'd0, 1, 48'h0000_1000_0040, 0, 0);
      // R2 hold across idle cycles
      cur_req = "R2";
      repeat (4) @(negedge clk);
      // R3 receiver disabled, phase must not move
      set_cfg(3'd0, 0, 0, 0, 0, 4'h0);
      pkt("R3", 2'd2, 0, 48'h10, 0, 0);
      set_cfg(3'd0, 1, 0, 0, 0, 4'h0);
      pkt("R3", 2'd0, 0, 48'h10, 0, 1);
      // R5 retry_X busy across modes
      for (int md = 0; md < 8; md++) begin
         set_cfg(3'(md), 1, 0, 0, 0, 4'h0);
         pkt("R5", 2'd1, 0, 48'h2000, 0, 1);
      end
      // R6 fixed codes, busy only when needed
      set_cfg(3'd1, 1, 0, 0, 0, 4'h0);
      pkt("R6", 2'd0, 0, 48'h2000, 0, 1);
      pkt("R6", 2'd0, 0, 48'h2000, 0, 0);
      set_cfg(3'd2, 1, 0, 0, 0, 4'h0);
      pkt("R6", 2'd2, 1, 48'h2000, 0, 1);
      pkt("R6", 2'd3, 1, 48'h2000, 0, 0);
      // R7 forced busy
      for (int md = 4; md < 7; md++) begin
         set_cfg(3'(md), 1, 0, 0, 0, 4'h0);
         pkt("R7", 2'd0, 0, 48'h3000, 0, 0);
         pkt("R7", 2'd2, 1, 48'h3000, 0, 0);
      end
      // R8 reserved modes act as normal
      set_cfg(3'd3, 1, 0, 0, 0, 4'h0);
      pkt("R8", 2'd0, 0, 48'h3000, 0, 0);
      pkt("R8", 2'd0, 0, 48'h3000, 0, 1);
      set_cfg(3'd7, 1, 0, 0, 0, 4'h0);
      pkt("R8", 2'd0, 1, 48'h3000, 0, 0);
      pkt("R8", 2'd0, 1, 48'h3000, 0, 1);
      // R9 physical busy
      set_cfg(3'd1, 1, 1, 0, 1, 4'h0);
      pkt("R9", 2'd0, 0, 48'h0000_FFFF_FFFC, 0, 0);
      pkt("R9", 2'd0, 0, 48'h0001_0000_0000, 0, 0);
      set_cfg(3'd2, 1, 1, 1, 1, 4'h0);
      pkt("R9", 2'd0, 1, 48'h0000_0000_0100, 0, 0);
      set_cfg(3'd1, 1, 0, 0, 1, 4'h0);
      pkt("R9", 2'd0, 1, 48'h0000_0000_0100, 0, 0);
      // R10 read-only reject
      set_cfg(3'd1, 1, 1, 1, 0, 4'h0);
      pkt("R10", 2'd0, 0, 48'h0000_0000_0100, 0, 0);
      pkt("R10", 2'd0, 1, 48'h0000_0000_0100, 0, 0);
      pkt("R10", 2'd0, 0, 48'h0001_0000_0100, 0, 0);
      set_cfg(3'd1, 1, 1, 1, 1, 4'h0);
      pkt("R10", 2'd0, 0, 48'h0000_0000_0100, 0, 0);
      // R11 broadcast filter by quarter
      for (int m = 0; m < 4; m++) begin
         set_cfg(3'd0, 1, 0, 0, 0, 4'(1 << m));
         for (int qq = 0; qq < 4; qq++) begin
            pkt("R11", 2'd0, 0, BD + 48'(qq * 128), 1, 0);
            pkt("R11", 2'd0, 0, BD + 48'(qq * 128 + 127), 1, 0);
         end
         pkt("R11", 2'd0, 0, BD - 48'd1, 1, 0);
         pkt("R11", 2'd0, 0, BD + 48'd512, 1, 0);
      end
      // R12 broadcast never acknowledged
      set_cfg(3'd0, 1, 0, 0, 0, 4'h0);
      pkt("R12", 2'd0, 0, 48'h4000, 1, 0);
      pkt("R12", 2'd0, 0, 48'h4000, 1, 1);
      set_cfg(3'd5, 1, 0, 0, 0, 4'h0);
      pkt("R12", 2'd0, 0, 48'h4000, 1, 0);
      // R13 dual-phase sequence
      set_cfg(3'd0, 1, 0, 0, 0, 4'h0);
      pkt("R13", 2'd3, 0, 48'h5000, 0, 0);
      pkt("R13", 2'd2, 0, 48'h5000, 0, 0);
      pkt("R13", 2'd0, 0, 48'h5000, 0, 1);
      pkt("R13", 2'd2, 0, 48'h5000, 0, 0);
      pkt("R13", 2'd3, 1, 48'h5000, 0, 0);
      pkt("R13", 2'd0, 0, 48'h5000, 0, 1);
      set_cfg(3'd4, 1, 0, 0, 0, 4'h0);
      pkt("R13", 2'd0, 0, 48'h5000, 0, 0);
      // R1 reset mid-run
      @(negedge clk);
      cur_req = "R1";
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      set_cfg(3'd0, 1, 0, 0, 0, 4'h0);
      pkt("R1", 2'd0, 0, 48'h5000, 0, 1);
      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule